// File: doc/BRIEF.md
# Accumulator Datapath with Field-Decoded Micro-Operations

This block is the data side of a small 16-bit accumulator processor. It holds four registers: a program counter and an address register, each as wide as a memory address (11 bits by default), and a data register and an accumulator, each as wide as a memory word (16 bits by default). A microprogrammed sequencer drives it through three 3-bit fields that are decoded side by side. All three fields take effect on the same rising clock edge. Every operation reads the register values from before that edge.

No shared bus connects the registers. Each register has its own source multiplexer, and its sources are restricted:
- The data register loads from the accumulator, from the program counter (zero-extended) or from memory.
- The address register loads from the program counter or from the low address bits of the data register.
- The program counter loads only from the address register, or increments.
- The accumulator receives the results of an arithmetic, logic and shift unit that works on the accumulator and the data register.

The memory port always shows the address register as the address and the data register as the write data. Read data can go only into the data register. The block also gives the sequencer the accumulator sign and zero status, and the indirect flag and opcode decoded from the data register. Instruction word layout: bit 15 is the indirect flag, bits 14:11 are the opcode, and bits 10:0 are the address.

Top module: `mux_acc_datapath`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero. After reset the zero status reads 1 and the sign status reads 0.
- R2: Field one (f1_op) codes that write the accumulator are 001 add the data register, 010 clear, 011 increment and 100 load the data register. Arithmetic wraps modulo 2^16.
- R3: Field two (f2_op) codes that write the accumulator are 001 subtract the data register, 010 bitwise OR and 011 bitwise AND with the data register.
- R4: Field three (f3_op) codes that write the accumulator are 001 XOR with the data register, 010 one's complement, 011 shift left and 100 shift right. Both shifts fill the vacated bit with zero and drop the bit shifted out.
- R5: All three fields act in the same edge using pre-edge register values. When more than one field writes the accumulator, f1_op wins over f2_op, and f2_op wins over f3_op.
- R6: f2_op loads the data register: 100 from mem_rdata (and raises mem_rd), 101 from the accumulator, 110 with the data register plus one (wrapping), 111 from the program counter zero-extended. f2_op codes 000 to 011 leave the data register unchanged.
- R7: f1_op 101 loads the address register from data register bits 10:0, and f1_op 110 loads it from the program counter. mem_addr always equals the address register.
- R8: f3_op 101 increments the program counter, wrapping from 0x7FF to 0. f3_op 110 loads the program counter from the address register.
- R9: f1_op 111 raises mem_wr during that cycle while mem_wdata shows the data register and mem_addr the address register. mem_rd is high only for f2_op 100. A write changes no register.
- R10: ac_sign equals accumulator bit 15. ac_zero is 1 exactly when the accumulator is all zeros. Both follow the accumulator in the same edge that updates it.
- R11: ir_indirect equals data register bit 15, and ir_opcode equals data register bits 14:11.
- R12: Code 000 in any field, and f3_op 111, change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| f1_op | input | 3 | Micro-operation field one |
| f2_op | input | 3 | Micro-operation field two |
| f3_op | input | 3 | Micro-operation field three |
| mem_rdata | input | 16 | Main-memory read data |
| mem_addr | output | 11 | Main-memory address (address register) |
| mem_wdata | output | 16 | Main-memory write data (data register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ac_sign | output | 1 | Accumulator sign status |
| ac_zero | output | 1 | Accumulator zero status |
| ir_indirect | output | 1 | Indirect flag from the data register |
| ir_opcode | output | 4 | Opcode from the data register |

## Verification
Each accumulator operation is tried on operands that give a result unlike either input and unlike every other operation's result, so a miswired decode code shows up. Carry, borrow and shift-out boundaries (0xFFFF+1, 5-7, 0x8001 shifted both ways, address wrap at 0x7FF) separate correct wrapping and zero fill from sign-extended or saturating variants. Field combinations that write the same register, or that read a register another field writes in the same edge, separate the stated priority and pre-edge sampling from later-value or reversed-priority behaviour. Accumulator and program counter contents are read out through the data register and the write data port.

// File: rtl/dp_uop_pkg.sv
package dp_uop_pkg;

  // Field one codes
  localparam logic [2:0] F1_NONE  = 3'b000;
  localparam logic [2:0] F1_ADD   = 3'b001;
  localparam logic [2:0] F1_CLR   = 3'b010;
  localparam logic [2:0] F1_INC   = 3'b011;
  localparam logic [2:0] F1_DR2AC = 3'b100;
  localparam logic [2:0] F1_DR2AR = 3'b101;
  localparam logic [2:0] F1_PC2AR = 3'b110;
  localparam logic [2:0] F1_WRITE = 3'b111;

  // Field two codes
  localparam logic [2:0] F2_NONE  = 3'b000;
  localparam logic [2:0] F2_SUB   = 3'b001;
  localparam logic [2:0] F2_OR    = 3'b010;
  localparam logic [2:0] F2_AND   = 3'b011;
  localparam logic [2:0] F2_READ  = 3'b100;
  localparam logic [2:0] F2_AC2DR = 3'b101;
  localparam logic [2:0] F2_INCDR = 3'b110;
  localparam logic [2:0] F2_PC2DR = 3'b111;

  // Field three codes
  localparam logic [2:0] F3_NONE  = 3'b000;
  localparam logic [2:0] F3_XOR   = 3'b001;
  localparam logic [2:0] F3_COM   = 3'b010;
  localparam logic [2:0] F3_SHL   = 3'b011;
  localparam logic [2:0] F3_SHR   = 3'b100;
  localparam logic [2:0] F3_INCPC = 3'b101;
  localparam logic [2:0] F3_AR2PC = 3'b110;

  typedef enum logic [3:0] {
    AC_HOLD, AC_ADD, AC_CLR, AC_INC, AC_LDDR, AC_SUB,
    AC_OR, AC_AND, AC_XOR, AC_COM, AC_SHL, AC_SHR
  } ac_op_e;

  typedef enum logic [2:0] {DR_HOLD, DR_MEM, DR_AC, DR_INC, DR_PC} dr_op_e;
  typedef enum logic [1:0] {AR_HOLD, AR_DR, AR_PC} ar_op_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_AR} pc_op_e;

  typedef struct packed {
    ac_op_e ac;
    dr_op_e dr;
    ar_op_e ar;
    pc_op_e pc;
    logic   mem_rd;
    logic   mem_wr;
  } uop_ctl_t;

endpackage

// File: rtl/dp_uop_decode.sv
module dp_uop_decode
  import dp_uop_pkg::*;
(
  input  logic [2:0] f1_op,
  input  logic [2:0] f2_op,
  input  logic [2:0] f3_op,
  output uop_ctl_t   ctl
);

  ac_op_e ac_f1, ac_f2, ac_f3;

  // accumulator requests, one per field
  always_comb begin
    case (f1_op)
      F1_ADD:   ac_f1 = AC_ADD;
      F1_CLR:   ac_f1 = AC_CLR;
      F1_INC:   ac_f1 = AC_INC;
      F1_DR2AC: ac_f1 = AC_LDDR;
      default:  ac_f1 = AC_HOLD;
    endcase
    case (f2_op)
      F2_SUB:   ac_f2 = AC_SUB;
      F2_OR:    ac_f2 = AC_OR;
      F2_AND:   ac_f2 = AC_AND;
      default:  ac_f2 = AC_HOLD;
    endcase
    case (f3_op)
      F3_XOR:   ac_f3 = AC_XOR;
      F3_COM:   ac_f3 = AC_COM;
      F3_SHL:   ac_f3 = AC_SHL;
      F3_SHR:   ac_f3 = AC_SHR;
      default:  ac_f3 = AC_HOLD;
    endcase
  end

  always_comb begin
    // field priority on the accumulator: one, then two, then three
    if (ac_f1 != AC_HOLD)      ctl.ac = ac_f1;
    else if (ac_f2 != AC_HOLD) ctl.ac = ac_f2;
    else                       ctl.ac = ac_f3;

    case (f2_op)
      F2_READ:  ctl.dr = DR_MEM;
      F2_AC2DR: ctl.dr = DR_AC;
      F2_INCDR: ctl.dr = DR_INC;
      F2_PC2DR: ctl.dr = DR_PC;
      default:  ctl.dr = DR_HOLD;
    endcase

    case (f1_op)
      F1_DR2AR: ctl.ar = AR_DR;
      F1_PC2AR: ctl.ar = AR_PC;
      default:  ctl.ar = AR_HOLD;
    endcase

    case (f3_op)
      F3_INCPC: ctl.pc = PC_INC;
      F3_AR2PC: ctl.pc = PC_AR;
      default:  ctl.pc = PC_HOLD;
    endcase

    ctl.mem_rd = (f2_op == F2_READ);
    ctl.mem_wr = (f1_op == F1_WRITE);
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_uop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  ac_op_e            op,
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] ac_next
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op)
      AC_ADD:  ac_next = ac + dr;
      AC_CLR:  ac_next = '0;
      AC_INC:  ac_next = ac + ONE;
      AC_LDDR: ac_next = dr;
      AC_SUB:  ac_next = ac - dr;
      AC_OR:   ac_next = ac | dr;
      AC_AND:  ac_next = ac & dr;
      AC_XOR:  ac_next = ac ^ dr;
      AC_COM:  ac_next = ~ac;
      AC_SHL:  ac_next = {ac[DATA_W-2:0], 1'b0};
      AC_SHR:  ac_next = {1'b0, ac[DATA_W-1:1]};
      default: ac_next = ac;
    endcase
  end

endmodule

// File: rtl/dp_ac_status.sv
module dp_ac_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ac_next,
  output logic              zero_q
);

  // zero flag registered alongside the accumulator
  always_ff @(posedge clk) begin
    if (rst) zero_q <= 1'b1;
    else     zero_q <= (ac_next == '0);
  end

endmodule

// File: rtl/mux_acc_datapath.sv
module mux_acc_datapath
  import dp_uop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        f1_op,
  input  logic [2:0]        f2_op,
  input  logic [2:0]        f3_op,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              ac_sign,
  output logic              ac_zero,
  output logic              ir_indirect,
  output logic [OPC_W-1:0]  ir_opcode
);

  localparam int PAD_W = DATA_W - ADDR_W;
  localparam int OPC_HI = DATA_W - 2;
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
  localparam logic [DATA_W-1:0] DR_ONE = DATA_W'(1);

  logic [ADDR_W-1:0] pc, ar;
  logic [DATA_W-1:0] dr, ac, ac_next;
  uop_ctl_t          ctl;

  dp_uop_decode u_decode (
    .f1_op (f1_op),
    .f2_op (f2_op),
    .f3_op (f3_op),
    .ctl   (ctl)
  );

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (ctl.ac),
    .ac      (ac),
    .dr      (dr),
    .ac_next (ac_next)
  );

  dp_ac_status #(.DATA_W(DATA_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .ac_next (ac_next),
    .zero_q  (ac_zero)
  );

  // accumulator
  always_ff @(posedge clk) begin
    if (rst) ac <= '0;
    else     ac <= ac_next;
  end

  // data register: memory, accumulator, increment, program counter
  always_ff @(posedge clk) begin
    if (rst) dr <= '0;
    else begin
      case (ctl.dr)
        DR_MEM:  dr <= mem_rdata;
        DR_AC:   dr <= ac;
        DR_INC:  dr <= dr + DR_ONE;
        DR_PC:   dr <= {{PAD_W{1'b0}}, pc};
        default: dr <= dr;
      endcase
    end
  end

  // address register: data register address field or program counter
  always_ff @(posedge clk) begin
    if (rst) ar <= '0;
    else begin
      case (ctl.ar)
        AR_DR:   ar <= dr[ADDR_W-1:0];
        AR_PC:   ar <= pc;
        default: ar <= ar;
      endcase
    end
  end

  // program counter: increment or address register
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else begin
      case (ctl.pc)
        PC_INC:  pc <= pc + PC_ONE;
        PC_AR:   pc <= ar;
        default: pc <= pc;
      endcase
    end
  end

  assign mem_addr    = ar;
  assign mem_wdata   = dr;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign ac_sign     = ac[DATA_W-1];
  assign ir_indirect = dr[DATA_W-1];
  assign ir_opcode   = dr[OPC_HI -: OPC_W];

  // ---------------- assertions ----------------
  p_clear_ac_r2: assert property (@(posedge clk) disable iff (rst)
    (f1_op == F1_CLR) |=> (ac == '0));

  p_shl_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (f1_op == F1_NONE && (f2_op == F2_NONE || f2_op[2]) && f3_op == F3_SHL)
      |=> (ac[0] == 1'b0));

  p_f1_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (f1_op == F1_DR2AC) |=> (ac == $past(dr)));

  p_dr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (f2_op[2] == 1'b0) |=> $stable(dr));

  p_ar_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (f1_op != F1_DR2AR && f1_op != F1_PC2AR) |=> $stable(ar));

  p_pc_inc_r8: assert property (@(posedge clk) disable iff (rst)
    (f3_op == F3_INCPC) |=> (pc == $past(pc) + PC_ONE));

  p_write_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (f1_op == F1_WRITE && f2_op == F2_NONE && f3_op == F3_NONE)
      |=> ($stable(ac) && $stable(pc) && $stable(dr) && $stable(ar)));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (rst)
    ac_zero == (ac == '0));

endmodule

// File: tb/test_mux_acc_datapath.sv
module test_mux_acc_datapath;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  f1_op = '0, f2_op = '0, f3_op = '0;
  logic [15:0] mem_rdata = '0;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rd, mem_wr, ac_sign, ac_zero, ir_indirect;
  logic [3:0]  ir_opcode;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  mux_acc_datapath i_mux_acc_datapath (
    .clk(clk), .rst(rst), .f1_op(f1_op), .f2_op(f2_op), .f3_op(f3_op),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ac_sign(ac_sign), .ac_zero(ac_zero),
    .ir_indirect(ir_indirect), .ir_opcode(ir_opcode)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // apply one micro-instruction for one edge, then return to no-op
  task automatic uop(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                     input logic [15:0] rd);
    f1_op = a; f2_op = b; f3_op = c; mem_rdata = rd;
    @(posedge clk); #1;
    f1_op = '0; f2_op = '0; f3_op = '0;
  endtask

  task automatic load_dr(input logic [15:0] v); uop(3'b000, 3'b100, 3'b000, v); endtask
  task automatic load_ac(input logic [15:0] v); load_dr(v); uop(3'b100, 3'b000, 3'b000, '0); endtask
  task automatic get_ac(output logic [15:0] v); uop(3'b000, 3'b101, 3'b000, '0); v = mem_wdata; endtask
  task automatic get_pc(output logic [15:0] v); uop(3'b000, 3'b111, 3'b000, '0); v = mem_wdata; endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 addr", mem_addr, 0);
    check("R1 wdata", mem_wdata, 0);
    check("R1 zero", ac_zero, 1);
    check("R1 sign", ac_sign, 0);
    get_ac(v); check("R1 ac", v, 0);
    get_pc(v); check("R1 pc", v, 0);
  endtask

  task automatic t_field1;
    logic [15:0] v;
    load_ac(16'h1234); load_dr(16'h0FFF); uop(3'b001, 0, 0, 0);
    get_ac(v); check("R2 add", v, 16'h2233);
    load_ac(16'hFFFF); load_dr(16'h0001); uop(3'b001, 0, 0, 0);
    check("R10 zero after wrap", ac_zero, 1);
    get_ac(v); check("R2 add wrap", v, 0);
    load_ac(16'h7FFF); uop(3'b011, 0, 0, 0);
    check("R10 sign after inc", ac_sign, 1);
    get_ac(v); check("R2 inc", v, 16'h8000);
    uop(3'b010, 0, 0, 0);
    check("R10 zero after clear", ac_zero, 1);
    get_ac(v); check("R2 clear", v, 0);
    load_dr(16'hBEEF); uop(3'b100, 0, 0, 0);
    get_ac(v); check("R2 dr to ac", v, 16'hBEEF);
  endtask

  task automatic t_field2;
    logic [15:0] v;
    load_ac(16'h0005); load_dr(16'h0007); uop(0, 3'b001, 0, 0);
    check("R10 sign", ac_sign, 1);
    check("R10 nonzero", ac_zero, 0);
    get_ac(v); check("R3 sub", v, 16'hFFFE);
    load_ac(16'hF00F); load_dr(16'h0FF0); uop(0, 3'b010, 0, 0);
    get_ac(v); check("R3 or", v, 16'hFFFF);
    load_ac(16'hF0F0); load_dr(16'h3C3C); uop(0, 3'b011, 0, 0);
    get_ac(v); check("R3 and", v, 16'h3030);
  endtask

  task automatic t_field3;
    logic [15:0] v;
    load_ac(16'hF0F0); load_dr(16'h3C3C); uop(0, 0, 3'b001, 0);
    get_ac(v); check("R4 xor", v, 16'hCCCC);
    load_ac(16'h1234); uop(0, 0, 3'b010, 0);
    get_ac(v); check("R4 complement", v, 16'hEDCB);
    load_ac(16'h8001); uop(0, 0, 3'b011, 0);
    get_ac(v); check("R4 shl", v, 16'h0002);
    load_ac(16'h8001); uop(0, 0, 3'b100, 0);
    get_ac(v); check("R4 shr", v, 16'h4000);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    load_ac(16'h00F0); load_dr(16'h0F0F);
    uop(3'b001, 3'b001, 3'b001, 0);
    get_ac(v); check("R5 f1 over f2 f3", v, 16'h0FFF);
    load_dr(16'h0F0F);
    uop(0, 3'b011, 3'b011, 0);
    get_ac(v); check("R5 f2 over f3", v, 16'h0F0F);
    uop(0, 3'b100, 3'b100, 16'h1111);
    check("R5 read with shift dr", mem_wdata, 16'h1111);
    uop(3'b100, 3'b100, 0, 16'h2222);
    check("R5 new dr", mem_wdata, 16'h2222);
    get_ac(v); check("R5 ac took old dr", v, 16'h1111);
    load_ac(16'h0F0F); uop(0, 0, 3'b100, 0);
    get_ac(v); check("R5 shr alone", v, 16'h0787);
  endtask

  task automatic t_dr;
    load_dr(16'hA55A); check("R6 mem read", mem_wdata, 16'hA55A);
    load_ac(16'h4321); load_dr(16'h0000); uop(0, 3'b101, 0, 0);
    check("R6 ac to dr", mem_wdata, 16'h4321);
    load_dr(16'hFFFF); uop(0, 3'b110, 0, 0);
    check("R6 inc wrap", mem_wdata, 16'h0000);
    load_dr(16'h1357); uop(0, 3'b001, 0, 16'hFFFF);
    check("R6 f2 alu code leaves dr", mem_wdata, 16'h1357);
  endtask

  task automatic t_ar_pc;
    logic [15:0] v;
    load_dr(16'hABCD); uop(3'b101, 3'b110, 0, 0);
    check("R7 dr to ar", mem_addr, 11'h3CD);
    check("R6 inc dr same edge", mem_wdata, 16'hABCE);
    uop(0, 0, 3'b110, 0);
    get_pc(v); check("R8 ar to pc", v, 16'h03CD);
    uop(3'b110, 0, 3'b101, 0);
    check("R7 pc to ar old pc", mem_addr, 11'h3CD);
    get_pc(v); check("R8 inc pc", v, 16'h03CE);
    uop(3'b110, 0, 0, 0);
    check("R7 pc to ar", mem_addr, 11'h3CE);
    load_dr(16'h07FF); uop(3'b101, 0, 0, 0); uop(0, 0, 3'b110, 0); uop(0, 0, 3'b101, 0);
    get_pc(v); check("R8 pc wrap", v, 0);
  endtask

  task automatic t_mem;
    logic [15:0] v;
    load_ac(16'h5A5A); load_dr(16'h1357); uop(3'b101, 0, 0, 0);
    f1_op = 3'b111; #1;
    check("R9 wr strobe", mem_wr, 1);
    check("R9 no rd", mem_rd, 0);
    check("R9 wdata", mem_wdata, 16'h1357);
    check("R9 addr", mem_addr, 11'h357);
    @(posedge clk); #1; f1_op = '0; #1;
    check("R9 wr released", mem_wr, 0);
    check("R9 dr kept", mem_wdata, 16'h1357);
    check("R9 ar kept", mem_addr, 11'h357);
    get_ac(v); check("R9 ac kept", v, 16'h5A5A);
    f2_op = 3'b100; #1;
    check("R9 rd strobe", mem_rd, 1);
    check("R9 rd no wr", mem_wr, 0);
    f2_op = '0; #1;
    check("R9 rd released", mem_rd, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_ir;
    load_dr(16'hD5AB);
    check("R11 indirect", ir_indirect, 1);
    check("R11 opcode", ir_opcode, 4'hA);
    load_dr(16'h3800);
    check("R11 indirect clear", ir_indirect, 0);
    check("R11 opcode 7", ir_opcode, 4'h7);
  endtask

  task automatic t_noop;
    logic [15:0] v;
    load_ac(16'h8421); load_dr(16'h0246); uop(3'b101, 0, 0, 0); uop(0, 0, 3'b110, 0);
    f3_op = 3'b111; mem_rdata = 16'hFFFF; #1;
    check("R12 no strobe rd", mem_rd, 0);
    check("R12 no strobe wr", mem_wr, 0);
    @(posedge clk); #1; f3_op = '0;
    uop(0, 0, 0, 16'hFFFF);
    check("R12 dr", mem_wdata, 16'h0246);
    check("R12 ar", mem_addr, 11'h246);
    check("R12 sign", ac_sign, 1);
    get_ac(v); check("R12 ac", v, 16'h8421);
    get_pc(v); check("R12 pc", v, 16'h0246);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    t_reset;
    t_field1;
    t_field2;
    t_field3;
    t_priority;
    t_dr;
    t_ar_pc;
    t_mem;
    t_ir;
    t_noop;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule